// File: doc/BRIEF.md
# I2C Multi-Message Transaction Sequencer

This block turns a list of I2C messages into the ordered stream of primitive bus operations that a bit-level engine carries out. Each message arrives as a descriptor with a 7-bit target address, a byte count, a flags byte and a marker for the final message of the transaction. For each message the sequencer requests a start or repeated start, sends the address byte, and then moves the data bytes. Write bytes come from an upstream byte stream and read bytes go out on a second stream. When the transaction ends, either normally or through an error, it closes the bus with a stop and reports a single result.

Each operation is one command to the engine, which returns exactly one response. Write responses carry the target's ACK or NACK, read responses carry the byte, and any response can signal a timeout. A NACKed address is retried with stop, a gap delay and a fresh start, up to a programmable number of retries. The result is either the number of messages completed or an error code.

The controlling state machine has these states: IDLE (waits for the first descriptor), NEXT_DESC (waits for the next descriptor of the same transaction), DISPATCH (chooses the start path or the data path), BEGIN (start or repeated start), ADDR (address byte), RSTOP, RGAP and RSTART (the three steps of a retry), WR_FETCH (takes a write byte), WR_BYTE (sends it), RD_BYTE (reads one byte), MSG_END (counts a finished message), FIN (decides whether to stop), STOP (final stop) and REPORT (one-cycle result). The transitions are:
- Accepting a descriptor leads from IDLE or NEXT_DESC to DISPATCH.
- DISPATCH goes to BEGIN, or straight to the data path when the message has no start.
- BEGIN goes to ADDR. ADDR goes to the data path, or to RSTOP to retry, or to FIN on an abort.
- A retry runs RSTOP, then RGAP, then RSTART, then back to ADDR.
- The data path cycles WR_FETCH and WR_BYTE, or repeats RD_BYTE, and reaches MSG_END when the count is used up. A zero count goes to MSG_END at once.
- MSG_END goes to NEXT_DESC, or to FIN after the final message.
- FIN goes to STOP or directly to REPORT. STOP goes to REPORT, and REPORT returns to IDLE.
- Any timeout, and any abort, leads to FIN.

Top module: `i2cseq_top`

## Requirements
- R1: The flags byte is decoded with these bit positions: bit 0 set means read and clear means write; bit 4 suppresses start and address; bit 5 ignores a NACK; bit 6 removes the acknowledge slot after read bytes; bit 7 suppresses the final stop. Command codes on `cmd_op` are 0 start, 1 repeated start, 2 stop, 3 write byte, 4 read byte and 5 gap delay. Acknowledge codes on `cmd_ack` are 0 send ACK, 1 send NACK and 2 no slot.
- R2: The first message of a transaction opens with a start and every later message with a repeated start. Either one is followed by a write of the address byte {addr[6:0], read bit}.
- R3: A message with the no-start flag issues neither start nor address and goes directly to its data bytes.
- R4: A NACKed address, while retries remain, is followed in order by a stop, a gap delay, a start and the same address byte. At most `cfg_retries`+1 address attempts are made per message.
- R5: A NACK on the last address attempt aborts with error code 1, unless the ignore-NACK flag is set; in that case the message goes on with its data.
- R6: Write bytes are taken from the write stream in order, one write-byte command each. A data NACK aborts with error code 2 unless the ignore-NACK flag is set.
- R7: Read bytes ask for ACK on all but the last byte of a message and NACK on the last. With the no-read-acknowledge flag they ask for no slot. Each read byte is delivered once on `rd_valid`/`rd_data`.
- R8: A timeout in any response before the final stop aborts with error code 3.
- R9: The transaction ends with a stop command unless the last message processed (including one that aborted) has the no-stop flag.
- R10: On success `done_err` is 0 and `done_code` equals the number of messages in the transaction. On abort `done_err` is 1 and `done_code` carries the error code.
- R11: `done_valid` is a one-cycle pulse. No descriptor is accepted between the start of a message and its end, or between the final message and the result, and the block is ready for a new transaction in the cycle after the result.
- R12: While `cmd_valid` is high and `cmd_ready` is low, the command and its data and acknowledge code stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_retries | input | RETRY_W | Extra address attempts allowed per message |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor can be taken |
| desc_addr | input | 7 | Target address |
| desc_flags | input | 8 | Message flags |
| desc_len | input | LEN_W | Byte count |
| desc_last | input | 1 | Final message of the transaction |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte delivered |
| rd_data | output | 8 | Read byte |
| cmd_valid | output | 1 | Command to the bit engine |
| cmd_ready | input | 1 | Engine takes the command |
| cmd_op | output | 3 | Command code |
| cmd_data | output | 8 | Byte to write |
| cmd_ack | output | 2 | Acknowledge code for a read |
| rsp_valid | input | 1 | Engine response |
| rsp_nack | input | 1 | Target answered NACK to a write |
| rsp_timeout | input | 1 | Operation timed out |
| rsp_data | input | 8 | Byte read |
| done_valid | output | 1 | Result pulse |
| done_err | output | 1 | Result is an error |
| done_code | output | MSG_W | Message count or error code |

## Verification
The assertions assume that the engine returns exactly one response for each accepted command, never an unsolicited one, and that the upstream side offers no further descriptors of a transaction after it has been aborted. The bench engine model asserts `cmd_ready` for one cycle only after seeing a command and holds it low otherwise, so a stalled command is exercised. It then answers once, with NACK or timeout chosen by a per-scenario write mask and command index. Scenarios that abort carry a single message, so no stray descriptor follows an error.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_RESTART = 3'd1,
        OP_STOP    = 3'd2,
        OP_WRITE   = 3'd3,
        OP_READ    = 3'd4,
        OP_DELAY   = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        AK_SEND = 2'd0,
        AK_NACK = 2'd1,
        AK_NONE = 2'd2
    } ackm_e;

    typedef struct packed {
        logic rd;
        logic no_start;
        logic ign_nack;
        logic no_rd_ack;
        logic no_stop;
    } mflags_t;

    localparam int FB_RD        = 0;
    localparam int FB_NO_START  = 4;
    localparam int FB_IGN_NACK  = 5;
    localparam int FB_NO_RD_ACK = 6;
    localparam int FB_NO_STOP   = 7;

    localparam int ERR_ADDR_NACK = 1;
    localparam int ERR_IO        = 2;
    localparam int ERR_TIMEOUT   = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_NEXT_DESC,
        ST_DISPATCH,
        ST_BEGIN,
        ST_ADDR,
        ST_RSTOP,
        ST_RGAP,
        ST_RSTART,
        ST_WR_FETCH,
        ST_WR_BYTE,
        ST_RD_BYTE,
        ST_MSG_END,
        ST_FIN,
        ST_STOP,
        ST_REPORT
    } state_e;

endpackage

// File: rtl/i2cseq_flag_dec.sv
module i2cseq_flag_dec
    import i2cseq_pkg::*;
(
    input  logic [7:0] raw,
    output mflags_t    fl
);
    logic [2:0] unused_bits;

    always_comb begin
        fl.rd        = raw[FB_RD];
        fl.no_start  = raw[FB_NO_START];
        fl.ign_nack  = raw[FB_IGN_NACK];
        fl.no_rd_ack = raw[FB_NO_RD_ACK];
        fl.no_stop   = raw[FB_NO_STOP];
        unused_bits  = raw[3:1];
    end
endmodule

// File: rtl/i2cseq_down_ctr.sv
module i2cseq_down_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         is_zero,
    output logic         is_one
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt - ONE;
        end
    end

    assign is_zero = (cnt == '0);
    assign is_one  = (cnt == ONE);

    // R4 / R7: neither retries nor bytes are consumed below zero
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> !is_zero);
endmodule

// File: rtl/i2cseq_byte_fmt.sv
module i2cseq_byte_fmt
    import i2cseq_pkg::*;
(
    input  logic [6:0] addr,
    input  logic       rd,
    input  logic       no_rd_ack,
    input  logic       last_byte,
    output logic [7:0] addr_byte,
    output ackm_e      ack_mode
);
    always_comb begin
        addr_byte = {addr, rd};
        if (no_rd_ack)      ack_mode = AK_NONE;
        else if (last_byte) ack_mode = AK_NACK;
        else                ack_mode = AK_SEND;
    end
endmodule

// File: rtl/i2cseq_top.sv
module i2cseq_top
    import i2cseq_pkg::*;
#(
    parameter int LEN_W   = 8,
    parameter int RETRY_W = 4,
    parameter int MSG_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RETRY_W-1:0] cfg_retries,
    input  logic               desc_valid,
    output logic               desc_ready,
    input  logic [6:0]         desc_addr,
    input  logic [7:0]         desc_flags,
    input  logic [LEN_W-1:0]   desc_len,
    input  logic               desc_last,
    input  logic               wr_valid,
    output logic               wr_ready,
    input  logic [7:0]         wr_data,
    output logic               rd_valid,
    output logic [7:0]         rd_data,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [2:0]         cmd_op,
    output logic [7:0]         cmd_data,
    output logic [1:0]         cmd_ack,
    input  logic               rsp_valid,
    input  logic               rsp_nack,
    input  logic               rsp_timeout,
    input  logic [7:0]         rsp_data,
    output logic               done_valid,
    output logic               done_err,
    output logic [MSG_W-1:0]   done_code
);
    localparam logic [MSG_W-1:0] MSG_ONE = {{(MSG_W-1){1'b0}}, 1'b1};

    state_e           state_q, state_d;
    logic             cmd_sent_q;
    logic [6:0]       addr_q;
    logic [7:0]       flags_q;
    logic             last_q;
    logic [7:0]       wbyte_q;
    logic [MSG_W-1:0] msg_cnt_q;
    logic             err_q;
    logic [MSG_W-1:0] err_code_q;
    logic             rd_valid_q;
    logic [7:0]       rd_data_q;

    mflags_t          fl;
    logic             desc_fire, wr_fire, cmd_fire, rsp_in;
    logic             abort_req;
    logic [MSG_W-1:0] abort_code;
    state_e           data_next;
    logic             cmd_state;

    logic [LEN_W-1:0]   byte_cnt;
    logic               byte_zero, byte_one, byte_dec;
    logic [RETRY_W-1:0] retry_cnt;
    logic               retry_zero, retry_dec;
    logic               unused_retry_one;
    logic [7:0]         addr_byte;
    ackm_e              ack_mode;

    i2cseq_flag_dec u_flags (
        .raw (flags_q),
        .fl  (fl)
    );

    i2cseq_down_ctr #(.W(LEN_W)) u_bytes (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (desc_fire),
        .load_val (desc_len),
        .dec      (byte_dec),
        .cnt      (byte_cnt),
        .is_zero  (byte_zero),
        .is_one   (byte_one)
    );

    i2cseq_down_ctr #(.W(RETRY_W)) u_retries (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (desc_fire),
        .load_val (cfg_retries),
        .dec      (retry_dec),
        .cnt      (retry_cnt),
        .is_zero  (retry_zero),
        .is_one   (unused_retry_one)
    );

    i2cseq_byte_fmt u_fmt (
        .addr      (addr_q),
        .rd        (fl.rd),
        .no_rd_ack (fl.no_rd_ack),
        .last_byte (byte_one),
        .addr_byte (addr_byte),
        .ack_mode  (ack_mode)
    );

    assign desc_fire = desc_valid && desc_ready;
    assign wr_fire   = wr_valid && wr_ready;
    assign cmd_fire  = cmd_valid && cmd_ready;
    assign rsp_in    = rsp_valid && cmd_sent_q;
    assign data_next = byte_zero ? ST_MSG_END : (fl.rd ? ST_RD_BYTE : ST_WR_FETCH);

    assign retry_dec = (state_q == ST_ADDR) && rsp_in && !rsp_timeout
                       && rsp_nack && !retry_zero;
    assign byte_dec  = rsp_in && !rsp_timeout &&
                       ((state_q == ST_RD_BYTE) ||
                        ((state_q == ST_WR_BYTE) && !(rsp_nack && !fl.ign_nack)));

    // Next-state decision
    always_comb begin
        state_d    = state_q;
        abort_req  = 1'b0;
        abort_code = '0;
        unique case (state_q)
            ST_IDLE, ST_NEXT_DESC: begin
                if (desc_fire) state_d = ST_DISPATCH;
            end
            ST_DISPATCH: begin
                state_d = fl.no_start ? data_next : ST_BEGIN;
            end
            ST_BEGIN, ST_RSTOP, ST_RGAP, ST_RSTART: begin
                if (rsp_in) begin
                    if (rsp_timeout) begin
                        abort_req  = 1'b1;
                        abort_code = MSG_W'(ERR_TIMEOUT);
                        state_d    = ST_FIN;
                    end else begin
                        unique case (state_q)
                            ST_BEGIN: state_d = ST_ADDR;
                            ST_RSTOP: state_d = ST_RGAP;
                            ST_RGAP:  state_d = ST_RSTART;
                            default:  state_d = ST_ADDR;
                        endcase
                    end
                end
            end
            ST_ADDR: begin
                if (rsp_in) begin
                    if (rsp_timeout) begin
                        abort_req  = 1'b1;
                        abort_code = MSG_W'(ERR_TIMEOUT);
                        state_d    = ST_FIN;
                    end else if (!rsp_nack) begin
                        state_d = data_next;
                    end else if (!retry_zero) begin
                        state_d = ST_RSTOP;
                    end else if (fl.ign_nack) begin
                        state_d = data_next;
                    end else begin
                        abort_req  = 1'b1;
                        abort_code = MSG_W'(ERR_ADDR_NACK);
                        state_d    = ST_FIN;
                    end
                end
            end
            ST_WR_FETCH: begin
                if (wr_fire) state_d = ST_WR_BYTE;
            end
            ST_WR_BYTE: begin
                if (rsp_in) begin
                    if (rsp_timeout) begin
                        abort_req  = 1'b1;
                        abort_code = MSG_W'(ERR_TIMEOUT);
                        state_d    = ST_FIN;
                    end else if (rsp_nack && !fl.ign_nack) begin
                        abort_req  = 1'b1;
                        abort_code = MSG_W'(ERR_IO);
                        state_d    = ST_FIN;
                    end else begin
                        state_d = byte_one ? ST_MSG_END : ST_WR_FETCH;
                    end
                end
            end
            ST_RD_BYTE: begin
                if (rsp_in) begin
                    if (rsp_timeout) begin
                        abort_req  = 1'b1;
                        abort_code = MSG_W'(ERR_TIMEOUT);
                        state_d    = ST_FIN;
                    end else begin
                        state_d = byte_one ? ST_MSG_END : ST_RD_BYTE;
                    end
                end
            end
            ST_MSG_END: state_d = last_q ? ST_FIN : ST_NEXT_DESC;
            ST_FIN:     state_d = fl.no_stop ? ST_REPORT : ST_STOP;
            ST_STOP: begin
                if (rsp_in) state_d = ST_REPORT;
            end
            ST_REPORT:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cmd_sent_q <= 1'b0;
            addr_q     <= '0;
            flags_q    <= '0;
            last_q     <= 1'b0;
            wbyte_q    <= '0;
            msg_cnt_q  <= '0;
            err_q      <= 1'b0;
            err_code_q <= '0;
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (cmd_fire)    cmd_sent_q <= 1'b1;
            else if (rsp_in) cmd_sent_q <= 1'b0;
            if (desc_fire) begin
                addr_q  <= desc_addr;
                flags_q <= desc_flags;
                last_q  <= desc_last;
            end
            if (wr_fire) wbyte_q <= wr_data;
            if (state_q == ST_MSG_END) msg_cnt_q <= msg_cnt_q + MSG_ONE;
            if (abort_req) begin
                err_q      <= 1'b1;
                err_code_q <= abort_code;
            end
            if (state_q == ST_REPORT) begin
                msg_cnt_q  <= '0;
                err_q      <= 1'b0;
                err_code_q <= '0;
            end
            rd_valid_q <= (state_q == ST_RD_BYTE) && rsp_in && !rsp_timeout;
            if ((state_q == ST_RD_BYTE) && rsp_in) rd_data_q <= rsp_data;
        end
    end

    // Outputs
    always_comb begin
        cmd_state = 1'b0;
        cmd_op    = OP_WRITE;
        cmd_data  = wbyte_q;
        cmd_ack   = AK_SEND;
        unique case (state_q)
            ST_BEGIN: begin
                cmd_state = 1'b1;
                cmd_op    = (msg_cnt_q == '0) ? OP_START : OP_RESTART;
            end
            ST_ADDR: begin
                cmd_state = 1'b1;
                cmd_op    = OP_WRITE;
                cmd_data  = addr_byte;
            end
            ST_RSTOP, ST_STOP: begin
                cmd_state = 1'b1;
                cmd_op    = OP_STOP;
            end
            ST_RGAP: begin
                cmd_state = 1'b1;
                cmd_op    = OP_DELAY;
            end
            ST_RSTART: begin
                cmd_state = 1'b1;
                cmd_op    = OP_START;
            end
            ST_WR_BYTE: begin
                cmd_state = 1'b1;
                cmd_op    = OP_WRITE;
            end
            ST_RD_BYTE: begin
                cmd_state = 1'b1;
                cmd_op    = OP_READ;
                cmd_ack   = ack_mode;
            end
            default: cmd_state = 1'b0;
        endcase
        cmd_valid  = cmd_state && !cmd_sent_q;
        desc_ready = (state_q == ST_IDLE) || (state_q == ST_NEXT_DESC);
        wr_ready   = (state_q == ST_WR_FETCH);
        rd_valid   = rd_valid_q;
        rd_data    = rd_data_q;
        done_valid = (state_q == ST_REPORT);
        done_err   = err_q;
        done_code  = err_q ? err_code_q : msg_cnt_q;
    end

    // R12: a stalled command is held unchanged
    assert_cmd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op)
                                        && $stable(cmd_data) && $stable(cmd_ack)));

    // R11: the result is a single-cycle pulse and is followed by readiness
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (!done_valid && desc_ready));

    // R2: a repeated start only follows a completed message
    assert_restart_later_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_RESTART) |-> (msg_cnt_q != '0));

    // R7: ACK is requested only while more than one byte remains
    assert_read_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_READ && cmd_ack == AK_SEND) |-> (byte_cnt > 1));

    // R7: a delivered read byte comes from an engine response one cycle earlier
    assert_rd_from_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rsp_valid));

    // R4: retries are spent only on an address NACK
    assert_retry_use_R4: assert property (@(posedge clk) disable iff (!rst_n)
        retry_dec |-> (rsp_valid && rsp_nack));
endmodule

// File: tb/tb_i2cseq_top.sv
module tb_i2cseq_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cfg_retries = '0;
    logic       desc_valid = 1'b0;
    logic       desc_ready;
    logic [6:0] desc_addr = '0;
    logic [7:0] desc_flags = '0;
    logic [7:0] desc_len = '0;
    logic       desc_last = 1'b0;
    logic       wr_valid = 1'b0;
    logic       wr_ready;
    logic [7:0] wr_data = '0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       cmd_valid;
    logic       cmd_ready = 1'b0;
    logic [2:0] cmd_op;
    logic [7:0] cmd_data;
    logic [1:0] cmd_ack;
    logic       rsp_valid = 1'b0;
    logic       rsp_nack = 1'b0;
    logic       rsp_timeout = 1'b0;
    logic [7:0] rsp_data = '0;
    logic       done_valid;
    logic       done_err;
    logic [7:0] done_code;

    always #5 clk = ~clk;

    i2cseq_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_retries(cfg_retries),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_addr(desc_addr),
        .desc_flags(desc_flags), .desc_len(desc_len), .desc_last(desc_last),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .cmd_ack(cmd_ack),
        .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_timeout(rsp_timeout),
        .rsp_data(rsp_data),
        .done_valid(done_valid), .done_err(done_err), .done_code(done_code)
    );

    localparam logic [2:0] C_START = 3'd0, C_RESTART = 3'd1, C_STOP = 3'd2,
                           C_WRITE = 3'd3, C_READ = 3'd4, C_DELAY = 3'd5;

    typedef struct packed {
        logic [7:0]  f0;
        logic [7:0]  l0;
        logic [7:0]  f1;
        logic [7:0]  l1;
        logic [1:0]  nmsg;
        logic [3:0]  ret;
        logic [15:0] mask;
        logic [7:0]  to;
        logic        eerr;
        logic [7:0]  ecode;
        logic [7:0]  ncmd;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 8'd2, 8'h00, 8'd0, 2'd1, 4'd0, 16'h0000, 8'hFF, 1'b0, 8'd1, 8'd5}, // R2 R6 R10
        '{8'h00, 8'd1, 8'h01, 8'd2, 2'd2, 4'd0, 16'h0000, 8'hFF, 1'b0, 8'd2, 8'd8}, // R2 R7
        '{8'h00, 8'd1, 8'h00, 8'd0, 2'd1, 4'd2, 16'h0001, 8'hFF, 1'b0, 8'd1, 8'd8}, // R4
        '{8'h00, 8'd1, 8'h00, 8'd0, 2'd1, 4'd1, 16'h0003, 8'hFF, 1'b1, 8'd1, 8'd7}, // R4 R5
        '{8'h20, 8'd1, 8'h00, 8'd0, 2'd1, 4'd1, 16'h0003, 8'hFF, 1'b0, 8'd1, 8'd8}, // R5
        '{8'h00, 8'd3, 8'h00, 8'd0, 2'd1, 4'd0, 16'h0002, 8'hFF, 1'b1, 8'd2, 8'd4}, // R6
        '{8'h20, 8'd2, 8'h00, 8'd0, 2'd1, 4'd0, 16'h0002, 8'hFF, 1'b0, 8'd1, 8'd5}, // R6
        '{8'h00, 8'd2, 8'h00, 8'd0, 2'd1, 4'd0, 16'h0000, 8'h02, 1'b1, 8'd3, 8'd4}, // R8
        '{8'h80, 8'd1, 8'h00, 8'd0, 2'd1, 4'd0, 16'h0000, 8'hFF, 1'b0, 8'd1, 8'd3}, // R9
        '{8'h00, 8'd1, 8'h10, 8'd1, 2'd2, 4'd0, 16'h0000, 8'hFF, 1'b0, 8'd2, 8'd5}, // R3
        '{8'h41, 8'd1, 8'h00, 8'd0, 2'd1, 4'd0, 16'h0000, 8'hFF, 1'b0, 8'd1, 8'd4}, // R7
        '{8'h80, 8'd2, 8'h00, 8'd0, 2'd1, 4'd0, 16'h0002, 8'hFF, 1'b1, 8'd2, 8'd3}, // R9
        '{8'h01, 8'd2, 8'h00, 8'd0, 2'd1, 4'd0, 16'h0000, 8'h02, 1'b1, 8'd3, 8'd4}  // R8
    };

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input logic ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Engine model state
    logic [15:0] eng_mask = '0;
    logic [7:0]  eng_to = 8'hFF;
    int          eng_cmd_n = 0;
    int          eng_wr_n = 0;
    int          eng_rd_n = 0;
    logic [2:0]  log_op [32];
    logic [7:0]  log_data [32];
    logic [1:0]  log_ack [32];
    logic [7:0]  rd_log [16];
    int          rd_n = 0;
    logic        pend = 1'b0;
    logic        pend_to = 1'b0;
    logic        pend_nack = 1'b0;
    logic [7:0]  pend_data = '0;
    logic        txn_fin = 1'b0;
    logic        got_err = 1'b0;
    logic [7:0]  got_code = '0;

    initial begin
        forever begin
            @(negedge clk);
            if (rsp_valid) begin
                rsp_valid   = 1'b0;
                rsp_nack    = 1'b0;
                rsp_timeout = 1'b0;
            end else if (pend) begin
                pend        = 1'b0;
                cmd_ready   = 1'b0;
                rsp_valid   = 1'b1;
                rsp_timeout = pend_to;
                rsp_nack    = pend_nack;
                rsp_data    = pend_data;
            end else if (cmd_valid) begin
                if (eng_cmd_n < 32) begin
                    log_op[eng_cmd_n]   = cmd_op;
                    log_data[eng_cmd_n] = cmd_data;
                    log_ack[eng_cmd_n]  = cmd_ack;
                end
                pend_to   = (eng_cmd_n == int'(eng_to));
                pend_nack = 1'b0;
                if (cmd_op == C_WRITE) begin
                    pend_nack = eng_mask[eng_wr_n];
                    eng_wr_n++;
                end
                if (cmd_op == C_READ) begin
                    pend_data = 8'h30 + 8'(eng_rd_n);
                    eng_rd_n++;
                end
                eng_cmd_n++;
                pend      = 1'b1;
                cmd_ready = 1'b1;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (rd_valid && rd_n < 16) begin
                rd_log[rd_n] = rd_data;
                rd_n++;
            end
        end
    end

    task automatic feed_desc(input vec_t v);
        for (int m = 0; m < int'(v.nmsg); m++) begin
            desc_addr  = (m == 0) ? 7'h2C : 7'h51;
            desc_flags = (m == 0) ? v.f0 : v.f1;
            desc_len   = (m == 0) ? v.l0 : v.l1;
            desc_last  = (m == int'(v.nmsg) - 1);
            desc_valid = 1'b1;
            while (!desc_ready && !txn_fin) @(negedge clk);
            if (!txn_fin) @(negedge clk);
            desc_valid = 1'b0;
        end
    endtask

    task automatic feed_wr(input vec_t v);
        int total = 0;
        if (!v.f0[0]) total += int'(v.l0);
        if (v.nmsg > 1 && !v.f1[0]) total += int'(v.l1);
        for (int k = 0; k < total; k++) begin
            wr_data  = 8'hC0 + 8'(k);
            wr_valid = 1'b1;
            while (!wr_ready && !txn_fin) @(negedge clk);
            if (!txn_fin) @(negedge clk);
            wr_valid = 1'b0;
        end
    endtask

    task automatic catch_done();
        int waited = 0;
        while (!done_valid && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        if (!done_valid) begin
            chk("R10 transaction timeout", 1'b0, 0, 1);
            got_err  = 1'bx;
            got_code = 8'hxx;
        end else begin
            got_err  = done_err;
            got_code = done_code;
        end
        txn_fin = 1'b1;
    endtask

    task automatic run_vec(input int i);
        vec_t v = VECS[i];
        @(negedge clk);
        eng_mask = v.mask; eng_to = v.to; eng_cmd_n = 0; eng_wr_n = 0; eng_rd_n = 0;
        rd_n = 0; txn_fin = 1'b0; cfg_retries = v.ret;
        fork
            feed_desc(v);
            feed_wr(v);
            catch_done();
        join
        desc_valid = 1'b0; wr_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    function automatic logic seq_ok(input logic [2:0] exp [], input int n);
        if (eng_cmd_n != n) return 1'b0;
        for (int k = 0; k < n; k++) if (log_op[k] != exp[k]) return 1'b0;
        return 1'b1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        chk("watchdog expired", 1'b0, 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [2:0] s1 [] = '{C_START, C_WRITE, C_WRITE, C_RESTART, C_WRITE, C_READ, C_READ, C_STOP};
        logic [2:0] s2 [] = '{C_START, C_WRITE, C_STOP, C_DELAY, C_START, C_WRITE, C_WRITE, C_STOP};
        logic [2:0] s9 [] = '{C_START, C_WRITE, C_WRITE, C_WRITE, C_STOP};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R11)
        chk("R11 reset desc_ready", desc_ready == 1'b1, desc_ready, 1);
        chk("R11 reset cmd_valid", cmd_valid == 1'b0, cmd_valid, 0);
        chk("R10 reset done_valid", done_valid == 1'b0, done_valid, 0);

        for (int i = 0; i < NV; i++) begin
            run_vec(i);
            chk($sformatf("R10 vec%0d done_err", i), got_err === VECS[i].eerr,
                got_err, VECS[i].eerr);
            chk($sformatf("R5/R6/R8/R10 vec%0d done_code", i), got_code === VECS[i].ecode,
                got_code, VECS[i].ecode);
            chk($sformatf("R4/R9 vec%0d command count", i), eng_cmd_n == int'(VECS[i].ncmd),
                eng_cmd_n, VECS[i].ncmd);
            chk($sformatf("R11 vec%0d ready after result", i), desc_ready == 1'b1,
                desc_ready, 1);
        end

        // Directed: two-message write then read
        run_vec(1);
        chk("R2 R1 command sequence", seq_ok(s1, 8), eng_cmd_n, 8);
        chk("R2 first address byte", log_data[1] == 8'h58, log_data[1], 8'h58);
        chk("R2 second address byte", log_data[4] == 8'hA3, log_data[4], 8'hA3);
        chk("R6 write data", log_data[2] == 8'hC0, log_data[2], 8'hC0);
        chk("R7 ack on first read", log_ack[5] == 2'd0, log_ack[5], 0);
        chk("R7 nack on last read", log_ack[6] == 2'd1, log_ack[6], 1);
        chk("R7 read count", rd_n == 2, rd_n, 2);
        chk("R7 read byte 0", rd_log[0] == 8'h30, rd_log[0], 8'h30);
        chk("R7 read byte 1", rd_log[1] == 8'h31, rd_log[1], 8'h31);

        // Directed: retry order and resent address
        run_vec(2);
        chk("R4 retry sequence", seq_ok(s2, 8), eng_cmd_n, 8);
        chk("R4 resent address", log_data[5] == 8'h58, log_data[5], 8'h58);

        // Directed: NACK ignored, data continues
        run_vec(4);
        chk("R5 data after ignored nack", log_op[6] == C_WRITE && log_data[6] == 8'hC0,
            log_data[6], 8'hC0);

        // Directed: no stop at end
        run_vec(8);
        chk("R9 no trailing stop", log_op[2] == C_WRITE, log_op[2], C_WRITE);
        run_vec(11);
        chk("R9 abort without stop", log_op[2] == C_WRITE, log_op[2], C_WRITE);

        // Directed: no-start message
        run_vec(9);
        chk("R3 no start sequence", seq_ok(s9, 5), eng_cmd_n, 5);
        chk("R3 second data byte", log_data[3] == 8'hC1, log_data[3], 8'hC1);

        // Directed: no read acknowledge slot, read address bit
        run_vec(10);
        chk("R7 no ack slot", log_ack[2] == 2'd2, log_ack[2], 2);
        chk("R1 read address bit", log_data[1] == 8'h59, log_data[1], 8'h59);

        // Directed: read timeout delivers no byte
        run_vec(12);
        chk("R8 no read byte on timeout", rd_n == 0, rd_n, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule